// File: doc/BRIEF.md
# Multiply Divide Unit

This unit does the two slow arithmetic instructions of a small 8-bit CPU: an unsigned multiply and an unsigned divide. Both work on the two ALU registers. The CPU gives the current register values and carry flag, picks the operation with one select bit, and pulses `start_i`. The unit then runs an iterative datapath. Multiply uses a shift-add loop, and divide uses a restoring subtract-and-shift loop. After the last iteration it gives a one-cycle `done_o` pulse. During that pulse it presents the new values for both registers and for the carry flag.

The select bit equals the least significant bit of the instruction code. The divide opcode is 1111_1010 and the multiply opcode is 1111_1011, so the decoder can route that bit straight to the unit. A divide by zero is caught when the operation is accepted. It finishes on the next cycle with a fixed result and the carry flag set.

Top module: `muldiv_unit`

## Requirements
- R1: `op_lsb_i` = 1 selects multiply and `op_lsb_i` = 0 selects divide. The select, operands and carry are sampled on the clock edge where a start is accepted.
- R2: Multiply returns the unsigned 16-bit product of the R0 and R1 operands. Bits 15:8 appear on `r0_o` and bits 7:0 appear on `r1_o`.
- R3: After a multiply, `c_o` equals the `c_i` value that was sampled at start.
- R4: A divide with a non-zero divisor returns the quotient R0 / R1 on `r0_o` and the remainder R0 mod R1 on `r1_o`, and it clears `c_o`.
- R5: A divide whose R1 operand is zero returns `r0_o` = 8'hFF, `r1_o` = 8'h00 and `c_o` = 1. `done_o` is high in the cycle right after the start edge, and `busy_o` never rises for that operation.
- R6: An accepted multiply, or a divide with a non-zero divisor, holds `busy_o` high for exactly 8 cycles starting the cycle after the start edge. `done_o` is then high for exactly one cycle, immediately after busy falls.
- R7: A `start_i` seen while `busy_o` is high is ignored. The running operation keeps its operands and its schedule, and a start in the `done_o` cycle is accepted.
- R8: While reset is asserted, `busy_o`, `done_o`, `r0_o`, `r1_o` and `c_o` are all 0.
- R9: `busy_o` and `done_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| op_lsb_i | input | 1 | 1 = multiply, 0 = divide |
| r0_i | input | 8 | R0 operand (multiplicand / dividend) |
| r1_i | input | 8 | R1 operand (multiplier / divisor) |
| c_i | input | 1 | Current carry flag |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion strobe |
| r0_o | output | 8 | New R0 value, valid with done |
| r1_o | output | 8 | New R1 value, valid with done |
| c_o | output | 1 | New carry flag, valid with done |

## Verification
The hardest case to reach from the ports is a start that lands in a cycle where the unit cannot take it: on each of the eight busy cycles, and on the exact `done_o` cycle where it must be taken. The bench holds `start_i` high for long stretches while it changes the operands and the select every cycle. Back-to-back operations, ignored requests and divide-by-zero completions on consecutive cycles therefore mix together. A behavioural model decides on every clock which request was accepted, and it checks that the result belongs to the operands sampled at that edge.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // Select encoding: matches the opcode least significant bit
  typedef enum logic {
    OP_DIV = 1'b0,
    OP_MUL = 1'b1
  } md_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } md_state_e;
endpackage

// File: rtl/muldiv_mul_step.sv
// One shift-add multiply iteration: {hi,lo} holds partial product and multiplier
module muldiv_mul_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] mcand_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W:0] sum;

  always_comb begin
    sum  = {1'b0, hi_i} + (lo_i[0] ? {1'b0, mcand_i} : '0);
    hi_o = sum[W:1];
    lo_o = {sum[0], lo_i[W-1:1]};
  end
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring divide iteration: rem holds partial remainder, quo the dividend/quotient
module muldiv_div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    diff    = shifted - {1'b0, dvs_i};
    fits    = (shifted >= {1'b0, dvs_i});
    rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/muldiv_ctrl.sv
// Sequencer: accepts a start when idle, counts ITER iterations, strobes done
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int ITER = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_div_i,
  output logic load_o,
  output logic zload_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  md_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic accept;

  always_comb begin
    accept  = start_i && (state_q == ST_IDLE);
    load_o  = accept && !zero_div_i;
    zload_o = accept && zero_div_i;
    step_o  = (state_q == ST_RUN);
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = zload_o;
    if (state_q == ST_RUN) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end
    end else if (load_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end
  end

  // rst_n is expected to deassert synchronously to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_run_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q != LAST) |=> busy_o);

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q == LAST) |=> (done_o && !busy_o));

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         op_lsb_i,
  input  logic [W-1:0] r0_i,
  input  logic [W-1:0] r1_i,
  input  logic         c_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] r0_o,
  output logic [W-1:0] r1_o,
  output logic         c_o
);
  localparam int ITER = W;

  md_op_e op_q, op_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d, opnd_q, opnd_d;
  logic c_q, c_d;
  logic load, zload, step, zero_div;
  logic [W-1:0] mul_hi, mul_lo, div_rem, div_quo;

  assign zero_div = (md_op_e'(op_lsb_i) == OP_DIV) && (r1_i == '0);

  muldiv_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_div_i(zero_div),
    .load_o(load), .zload_o(zload), .step_o(step),
    .busy_o(busy_o), .done_o(done_o)
  );

  muldiv_mul_step #(.W(W)) u_mul (
    .hi_i(hi_q), .lo_i(lo_q), .mcand_i(opnd_q), .hi_o(mul_hi), .lo_o(mul_lo)
  );

  muldiv_div_step #(.W(W)) u_div (
    .rem_i(hi_q), .quo_i(lo_q), .dvs_i(opnd_q), .rem_o(div_rem), .quo_o(div_quo)
  );

  always_comb begin
    op_d   = op_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    opnd_d = opnd_q;
    c_d    = c_q;
    if (zload) begin
      op_d = OP_DIV;
      hi_d = '0;
      lo_d = '1;
      c_d  = 1'b1;
    end else if (load) begin
      op_d = md_op_e'(op_lsb_i);
      hi_d = '0;
      if (md_op_e'(op_lsb_i) == OP_MUL) begin
        lo_d   = r1_i;
        opnd_d = r0_i;
        c_d    = c_i;
      end else begin
        lo_d   = r0_i;
        opnd_d = r1_i;
        c_d    = 1'b0;
      end
    end else if (step) begin
      hi_d = (op_q == OP_MUL) ? mul_hi : div_rem;
      lo_d = (op_q == OP_MUL) ? mul_lo : div_quo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_DIV;
      hi_q   <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
      c_q    <= 1'b0;
    end else begin
      op_q   <= op_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      opnd_q <= opnd_d;
      c_q    <= c_d;
    end
  end

  // Multiply: high half on R0; divide: quotient on R0, remainder on R1
  assign r0_o = (op_q == OP_MUL) ? hi_q : lo_q;
  assign r1_o = (op_q == OP_MUL) ? lo_q : hi_q;
  assign c_o  = c_q;

  p_divzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !op_lsb_i && r1_i == '0)
      |=> (done_o && !busy_o && r0_o == '1 && r1_o == '0 && c_o));

  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q == OP_DIV && !c_o) |-> (r1_o < opnd_q));

  p_mul_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_lsb_i) |=> (c_o == $past(c_i)));
endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_lsb = 1'b0, c_in = 1'b0;
  logic [7:0] r0_in = '0, r1_in = '0;
  logic busy, done, c_out;
  logic [7:0] r0_out, r1_out;

  always #2.5 clk = ~clk;

  muldiv_unit #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_lsb_i(op_lsb),
    .r0_i(r0_in), .r1_i(r1_in), .c_i(c_in),
    .busy_o(busy), .done_o(done), .r0_o(r0_out), .r1_o(r1_out), .c_o(c_out)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_busy, m_cnt, m_done, m_r0, m_r1, m_c;
  int p_r0, p_r1, p_c;
  string m_tag, p_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_r0 = 0; m_r1 = 0; m_c = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_cnt++;
        if (m_cnt == 8) begin
          m_busy = 0; m_done = 1;
          m_r0 = p_r0; m_r1 = p_r1; m_c = p_c; m_tag = p_tag;
        end
      end else if (start) begin
        if (op_lsb) begin                       // R1: 1 = multiply
          p_r0 = (r0_in * r1_in) / 256;
          p_r1 = (r0_in * r1_in) % 256;
          p_c = c_in;
          p_tag = "R2 R3 mul";
          m_busy = 1; m_cnt = 0;
        end else if (r1_in == 0) begin          // R5
          m_done = 1; m_r0 = 255; m_r1 = 0; m_c = 1; m_tag = "R5 divzero";
        end else begin                          // R1: 0 = divide, R4
          p_r0 = r0_in / r1_in;
          p_r1 = r0_in % r1_in;
          p_c = 0;
          p_tag = "R4 div";
          m_busy = 1; m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 R7 busy", busy, m_busy);
      chk("R6 R7 done", done, m_done);
      chk("R9 overlap", busy && done, 0);
      if (m_done != 0) begin
        chk({m_tag, " r0"}, r0_out, m_r0);
        chk({m_tag, " r1"}, r1_out, m_r1);
        chk({m_tag, " c"}, c_out, m_c);
      end
    end
  end

  task automatic run_op(bit mul, int a, int b, bit c);
    @(negedge clk); #1;
    start = 1; op_lsb = mul; r0_in = 8'(a); r1_in = 8'(b); c_in = c;
    @(negedge clk); #1;
    start = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 busy", busy, 0);
    chk("R8 done", done, 0);
    chk("R8 r0", r0_out, 0);
    chk("R8 r1", r1_out, 0);
    chk("R8 c", c_out, 0);
    #1 rst_n = 1;

    // R2 R3 multiply patterns
    run_op(1, 8'h12, 8'h34, 0);
    run_op(1, 255, 255, 1);
    run_op(1, 0, 200, 1);
    run_op(1, 1, 1, 0);
    run_op(1, 128, 2, 1);
    // R4 divide patterns
    run_op(0, 255, 1, 1);
    run_op(0, 7, 9, 1);
    run_op(0, 200, 7, 0);
    run_op(0, 0, 5, 1);
    run_op(0, 255, 255, 0);
    run_op(0, 100, 128, 1);
    // R5 divide by zero
    run_op(0, 42, 0, 0);
    run_op(0, 0, 0, 1);

    // R7: start held high with operands and select changing every cycle
    @(negedge clk); #1;
    start = 1;
    for (int i = 0; i < 60; i++) begin
      op_lsb = (i % 3) != 0;
      r0_in = 8'(i * 37 + 11);
      r1_in = ((i % 5) == 0) ? 8'd0 : 8'(i * 13 + 3);
      c_in = i[1];
      @(negedge clk); #1;
    end
    // R5 back-to-back divide by zero
    op_lsb = 0; r1_in = 0;
    repeat (4) @(negedge clk);
    #1 start = 0;
    repeat (12) @(negedge clk);

    // R8: reset in the middle of an operation
    run_op(1, 9, 9, 1);
    @(negedge clk); #1 start = 1; op_lsb = 1;
    @(negedge clk); #1 start = 0;
    @(negedge clk); #1 rst_n = 0;
    @(negedge clk);
    chk("R8 mid busy", busy, 0);
    chk("R8 mid done", done, 0);
    chk("R8 mid r0", r0_out, 0);
    chk("R8 mid c", c_out, 0);
    #1 rst_n = 1;
    run_op(0, 77, 10, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule